// File: doc/BRIEF.md
# MLT-3 Line Decoder and 5-Bit Symbol Deserializer

This block sits behind a clock-recovery stage in a 100 Mb/s twisted-pair receiver. Each cycle of `clk` is one bit time. When `line_valid` is high, a three-level line sample arrives on `line_level`. The block turns each level transition into a data one and each repeated level into a zero, which undoes both the three-level coding and the NRZI step in one comparison. It then packs the recovered bits into 5-bit symbols. It does not descramble them, and it does not align them to frame delimiters; symbol boundaries simply run freely from reset.

Symbols leave as a valid/ready stream. A symbol stays on `sym_data` with `sym_valid` high until the consumer takes it with `sym_ready`. The line cannot be stalled, so back-pressure cannot slow the input. If a new symbol completes while the old one has not been taken, the new one replaces it. If it completes in the same cycle that the old one is taken, `sym_valid` stays high and no symbol is lost.

The block also produces a symbol-rate clock strobe, `sym_clk`. It falls exactly when the symbol register loads and rises while that register is steady. A signal-detect flag watches the wire for activity. An active-low loopback select feeds the local transmit encoder's stream into the decoder in place of the line. A speed select, when low, mutes symbol output.

Top module: `mlt3_symbol_rx`

## Requirements
- R1: Level codes are 2'b00 zero, 2'b01 positive, 2'b11 negative, and 2'b10 is read as zero. An accepted sample decodes to 1 when its level differs from the previously accepted level, and to 0 otherwise. The previous level is zero after reset. A cycle with the selected valid low is ignored.
- R2: Every SYM_W (5) accepted bits form one symbol. The first bit of the symbol lands in the MSB (bit 4). The symbol appears on `sym_data` with `sym_valid` high in the cycle after the clock edge that accepted its fifth bit.
- R3: `sym_clk` falls on the same edge that loads a new symbol. It rises on the edge that accepts the third bit of the following symbol. `sym_data` never changes on a rising edge of `sym_clk`.
- R4: While `sym_valid` is high and `sym_ready` is low, `sym_valid` stays high and `sym_data` holds, unless a new symbol completes. A symbol that completes in the same cycle as a handshake keeps `sym_valid` high with the new data.
- R5: When `lpbk_n` is low, `tx_level`/`tx_valid` replace `line_level`/`line_valid` as the decoder input.
- R6: While `sig_det` is low, it rises after SD_CNT (16) valid line samples with a nonzero level. Zero samples do not reset this count.
- R7: While `sig_det` is high, it falls after SD_CNT consecutive valid zero-level line samples. A nonzero sample restarts this run.
- R8: `sig_det` always watches `line_level`/`line_valid`, whatever the values of `lpbk_n` and `sel_100`.
- R9: While `sel_100` is low, `sym_valid` and `sym_clk` are 0 and any pending symbol is dropped. After `sel_100` returns high, the next accepted bit is the MSB of a new symbol.
- R10: After reset, `sym_valid`, `sym_clk`, `sig_det` and `sym_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_level | input | 2 | Recovered line level code |
| line_valid | input | 1 | Line sample present this cycle |
| tx_level | input | 2 | Level code from the local transmit encoder |
| tx_valid | input | 1 | Transmit sample present this cycle |
| lpbk_n | input | 1 | Low selects the transmit stream as decoder input |
| sel_100 | input | 1 | High enables 100 Mb/s symbol output |
| sym_data | output | SYM_W | Received symbol, first bit in MSB |
| sym_valid | output | 1 | Symbol available |
| sym_ready | input | 1 | Consumer takes the symbol |
| sym_clk | output | 1 | Symbol-rate clock strobe |
| sig_det | output | 1 | Line activity detected |

## Verification
Two events can fall in the same cycle: a symbol completing on its fifth accepted bit, and the consumer's handshake on the previous symbol. The bench provokes this with directed stalls that release `sym_ready` exactly on a fifth bit. It also provokes it with random ready and valid patterns. A bench model judges the result: it must show `sym_valid` still high, carrying the new symbol, with no gap. A second overlap is the `sig_det` threshold being reached while loopback or a low speed select is active. The bench judges this by checking that detection follows only the wire.

// File: rtl/mlt3_rx_pkg.sv
package mlt3_rx_pkg;
  typedef enum logic [1:0] {
    LV_ZERO = 2'b00,
    LV_POS  = 2'b01,
    LV_RSVD = 2'b10,
    LV_NEG  = 2'b11
  } level_t;

  // Reserved code is read as the zero level
  function automatic logic [1:0] norm_level(input logic [1:0] lv);
    return (lv == LV_RSVD) ? LV_ZERO : lv;
  endfunction

  function automatic logic is_active(input logic [1:0] lv);
    return norm_level(lv) != LV_ZERO;
  endfunction
endpackage

// File: rtl/mlt3_bit_decode.sv
module mlt3_bit_decode
  import mlt3_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_level,
  input  logic       line_valid,
  input  logic [1:0] tx_level,
  input  logic       tx_valid,
  input  logic       lpbk_n,
  output logic       bit_val,
  output logic       bit_valid
);
  logic [1:0] src_level;
  logic       src_valid;
  logic [1:0] prev_q;

  // R5: loopback source select
  always_comb begin
    src_level = lpbk_n ? line_level : tx_level;
    src_valid = lpbk_n ? line_valid : tx_valid;
  end

  // R1: transition means one
  always_comb begin
    bit_val   = norm_level(src_level) != prev_q;
    bit_valid = src_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= LV_ZERO;
    else if (src_valid) prev_q <= norm_level(src_level);
  end

  // R1: an idle cycle leaves the reference level alone
  a_r1_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> $stable(prev_q));
endmodule

// File: rtl/mlt3_sig_detect.sv
module mlt3_sig_detect
  import mlt3_rx_pkg::*;
#(
  parameter int SD_CNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_level,
  input  logic       line_valid,
  output logic       sig_det
);
  localparam int CW = $clog2(SD_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(SD_CNT - 1);

  logic [CW-1:0] cnt_q;
  logic          det_q;
  logic          act;

  assign act     = is_active(line_level);
  assign sig_det = det_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      det_q <= 1'b0;
    end else if (line_valid) begin
      if (!det_q) begin
        // R6: cumulative count of active samples
        if (act) begin
          if (cnt_q == LAST) begin
            det_q <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else begin
        // R7: run of quiet samples
        if (act) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          det_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r6_rise_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> $past(line_valid && act));
  a_r7_fall_on_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_q) |-> $past(line_valid && !act));
endmodule

// File: rtl/mlt3_symbol_deser.sv
module mlt3_symbol_deser #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_val,
  input  logic             bit_valid,
  input  logic             sel_100,
  input  logic             sym_ready,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_valid,
  output logic             sym_clk
);
  localparam int PW = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(SYM_W - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(SYM_W / 2);

  logic [SYM_W-2:0] sh_q;
  logic [PW-1:0]    ph_q;
  logic [SYM_W-1:0] data_q;
  logic             val_q;
  logic             sclk_q;
  logic             load;
  logic             take;

  assign load      = sel_100 && bit_valid && (ph_q == PH_LAST);
  assign take      = val_q && sym_ready;
  assign sym_data  = data_q;
  assign sym_valid = val_q;
  assign sym_clk   = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      ph_q   <= '0;
      data_q <= '0;
      val_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else if (!sel_100) begin
      // R9: muted, restart symbol framing
      ph_q   <= '0;
      val_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      if (bit_valid) begin
        sh_q <= {sh_q[SYM_W-3:0], bit_val};
        if (ph_q == PH_LAST) begin
          data_q <= {sh_q, bit_val};   // R2: first bit in MSB
          sclk_q <= 1'b0;              // R3: falls with the load
          ph_q   <= '0;
        end else begin
          if (ph_q == PH_MID) sclk_q <= 1'b1;
          ph_q <= ph_q + 1'b1;
        end
      end
      val_q <= (val_q && !take) || load;  // R4
    end
  end

  a_r3_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q != $past(data_q)) |-> $fell(sclk_q));
  a_r3_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(data_q));
  a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q && !sym_ready && sel_100) |=> val_q);
  a_r4_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q && !sym_ready && !load) |=> $stable(data_q));
  a_r9_muted: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_100 |=> (!val_q && !sclk_q));
endmodule

// File: rtl/mlt3_symbol_rx.sv
module mlt3_symbol_rx #(
  parameter int SYM_W  = 5,
  parameter int SD_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       line_level,
  input  logic             line_valid,
  input  logic [1:0]       tx_level,
  input  logic             tx_valid,
  input  logic             lpbk_n,
  input  logic             sel_100,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_valid,
  input  logic             sym_ready,
  output logic             sym_clk,
  output logic             sig_det
);
  logic dec_bit;
  logic dec_valid;

  mlt3_bit_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_level (line_level),
    .line_valid (line_valid),
    .tx_level   (tx_level),
    .tx_valid   (tx_valid),
    .lpbk_n     (lpbk_n),
    .bit_val    (dec_bit),
    .bit_valid  (dec_valid)
  );

  // R8: detection always taps the wire
  mlt3_sig_detect #(.SD_CNT(SD_CNT)) u_sd (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_level (line_level),
    .line_valid (line_valid),
    .sig_det    (sig_det)
  );

  mlt3_symbol_deser #(.SYM_W(SYM_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_val   (dec_bit),
    .bit_valid (dec_valid),
    .sel_100   (sel_100),
    .sym_ready (sym_ready),
    .sym_data  (sym_data),
    .sym_valid (sym_valid),
    .sym_clk   (sym_clk)
  );
endmodule

// File: tb/tb_mlt3_symbol_rx.sv
module tb_mlt3_symbol_rx;
  localparam int SYM_W = 5;
  localparam int SD_CNT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] line_level = 2'b00, tx_level = 2'b00;
  logic line_valid = 1'b0, tx_valid = 1'b0, lpbk_n = 1'b1, sel_100 = 1'b1;
  logic sym_ready = 1'b0;
  logic [SYM_W-1:0] sym_data;
  logic sym_valid, sym_clk, sig_det;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mlt3_symbol_rx #(.SYM_W(SYM_W), .SD_CNT(SD_CNT)) dut (
    .clk(clk), .rst_n(rst_n), .line_level(line_level), .line_valid(line_valid),
    .tx_level(tx_level), .tx_valid(tx_valid), .lpbk_n(lpbk_n), .sel_100(sel_100),
    .sym_data(sym_data), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_clk(sym_clk), .sig_det(sig_det));

  // reference state built from the requirements
  logic [1:0] m_prev;
  logic [3:0] m_sh;
  int m_ph, m_cnt;
  logic [4:0] m_data;
  logic m_val, m_sclk, m_sd;
  int overlap_seen = 0;

  function automatic logic [1:0] nz(input logic [1:0] l);
    return (l == 2'b10) ? 2'b00 : l;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = 2'b00; m_sh = '0; m_ph = 0; m_cnt = 0;
    m_data = '0; m_val = 0; m_sclk = 0; m_sd = 0;
  endtask

  task automatic model_edge();
    logic [1:0] lv;
    logic vv, b, load, acc;
    lv = lpbk_n ? line_level : tx_level;
    vv = lpbk_n ? line_valid : tx_valid;
    b = nz(lv) != m_prev;
    load = 0;
    acc = m_val && sym_ready;
    if (!sel_100) begin
      m_ph = 0; m_val = 0; m_sclk = 0;
    end else begin
      if (vv) begin
        if (m_ph == 4) begin
          m_data = {m_sh, b}; load = 1; m_sclk = 0; m_ph = 0;
        end else begin
          if (m_ph == 2) m_sclk = 1;
          m_ph++;
        end
        m_sh = {m_sh[2:0], b};
      end
      if (load && acc) overlap_seen++;
      m_val = (m_val && !acc) || load;
    end
    if (vv) m_prev = nz(lv);
    if (line_valid) begin
      if (!m_sd) begin
        if (nz(line_level) != 2'b00) begin
          if (m_cnt == SD_CNT - 1) begin m_sd = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end else begin
        if (nz(line_level) != 2'b00) m_cnt = 0;
        else if (m_cnt == SD_CNT - 1) begin m_sd = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R2 sym_data", 32'(sym_data), 32'(m_data));
    check("R4 sym_valid", 32'(sym_valid), 32'(m_val));
    check("R3 sym_clk", 32'(sym_clk), 32'(m_sclk));
    check("R6/R7 sig_det", 32'(sig_det), 32'(m_sd));
  endtask

  task automatic do_reset();
    rst_n = 0; line_valid = 0; tx_valid = 0; line_level = 0; tx_level = 0;
    lpbk_n = 1; sel_100 = 1; sym_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] seq [5];
    void'($urandom(32'h5eed1234));
    do_reset();
    // R10 reset state
    check("R10 sym_valid", 32'(sym_valid), 0);
    check("R10 sym_clk", 32'(sym_clk), 0);
    check("R10 sig_det", 32'(sig_det), 0);
    check("R10 sym_data", 32'(sym_data), 0);

    // R5/R8: loopback symbol 10110 from tx, line silent but valid
    seq = '{2'b01, 2'b01, 2'b00, 2'b11, 2'b11};
    lpbk_n = 0; line_valid = 1; line_level = 2'b00;
    for (int i = 0; i < 5; i++) begin
      tx_valid = 1; tx_level = seq[i];
      cyc();
    end
    check("R5 loopback symbol", 32'(sym_data), 32'h16);
    check("R5 loopback valid", 32'(sym_valid), 1);
    check("R8 sig_det ignores loopback", 32'(sig_det), 0);
    sym_ready = 1; tx_valid = 0; cyc(); sym_ready = 0;
    lpbk_n = 1;

    // R1: reserved code reads as zero, no transition from zero
    do_reset();
    line_valid = 1;
    line_level = 2'b10; cyc();
    line_level = 2'b00; cyc();
    line_level = 2'b11; cyc();
    line_level = 2'b11; cyc();
    line_level = 2'b01; cyc();
    check("R1 decode 00101", 32'(sym_data), 32'h05);

    // R8/R9: muted speed select, detection still runs on line
    sel_100 = 0;
    for (int i = 0; i < SD_CNT; i++) begin
      line_level = (i % 2) ? 2'b01 : 2'b11; cyc();
    end
    check("R9 muted valid", 32'(sym_valid), 0);
    check("R8 sig_det with sel_100 low", 32'(sig_det), 1);
    sel_100 = 1;

    // R4: release ready exactly on a fifth bit
    for (int k = 0; k < 4; k++) begin
      sym_ready = 0;
      while (!(m_val && m_ph == 4)) begin
        line_level = 2'($urandom_range(0, 3)); cyc();
      end
      sym_ready = 1; line_level = 2'($urandom_range(0, 3)); cyc();
      check("R4 overlap keeps valid", 32'(sym_valid), 1);
    end
    sym_ready = 0;

    // R7: quiet run drops detection
    line_level = 2'b00;
    repeat (SD_CNT) cyc();
    check("R7 sig_det fall", 32'(sig_det), 0);

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      line_valid = ($urandom_range(0, 9) < 8);
      tx_valid   = ($urandom_range(0, 9) < 8);
      line_level = (n % 1500 < 300) ? 2'b00 : 2'($urandom_range(0, 3));
      tx_level   = 2'($urandom_range(0, 3));
      sym_ready  = ($urandom_range(0, 9) < 6);
      if (n % 200 == 0) lpbk_n = ($urandom_range(0, 3) != 0);
      if (n % 300 == 0) sel_100 = ($urandom_range(0, 4) != 0);
      cyc();
    end
    check("R4 overlap exercised", 32'(overlap_seen > 4), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule